// File: doc/BRIEF.md
# Sinc Bitstream Decimator

This block turns a one-bit delta-sigma bitstream into multi-bit signed samples. It applies a second- or third-order sinc low-pass filter, built as a chain of running-sum integrators followed by a difference stage. Each input bit enters the first integrator as a two's-complement value: a one adds +1 and a zero adds 0. Every following integrator adds the value of the stage before it.

Every R input samples, the last active integrator is read. The newest reading and the older stored readings are combined by repeated differencing into one output sample. For a steady bit density of k ones per R samples, the output settles at k·R^(N−1), where N is the filter order.

The bitstream comes either from a data pin sampled on every system clock, or from a data pin paired with an external bit clock. In the second case only the rising edges of the bit clock count, and the decimation period is measured in those edges. Mode, order and ratio are captured only while the block is idle (`run_i` low). While it is idle, all filter state is held cleared.

Top module: `sinc_decimator`

## Requirements
- R1: After reset, `out_valid_o` is 0 and `out_data_o` is 0.
- R2: In internal mode (`ext_mode_i`=0), one data bit is taken every system clock. A 1 contributes +1 and a 0 contributes 0. With order 2 and a steady pattern of k ones per R bits, every valid output equals k·R.
- R3: `order3_i`=1 selects a third-order filter, whose steady output for k ones per R bits is k·R². `order3_i`=0 selects second order.
- R4: In external mode (`ext_mode_i`=1), a bit is taken only at a synchronized rising edge of `bit_clk_i`. The ratio is counted in those edges, so outputs are spaced R bit-clock periods apart.
- R5: In internal mode, activity on `bit_clk_i` has no effect on the outputs.
- R6: After `run_i` rises, the first valid output comes at the (order+1)-th decimation boundary. Nothing is valid before it. In internal mode this is exactly (order+1)·R cycles after the first running clock edge.
- R7: `out_valid_o` is a one-cycle pulse. Consecutive pulses are exactly R input samples apart.
- R8: All integrator and difference arithmetic wraps modulo 2^ACC_W. The output is the exact result reduced modulo 2^ACC_W.
- R9: `ext_mode_i`, `order3_i` and `ratio_i` are captured only while `run_i` is 0. Changes made while running have no effect. A ratio below 2 is used as 2.
- R10: While `run_i` is 0, no output is valid and the filter state is cleared, so every restart primes again from empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | 1 = filter running; 0 = idle, state cleared, configuration captured |
| ext_mode_i | input | 1 | 1 = sample on external bit clock rising edges; 0 = sample every system clock |
| order3_i | input | 1 | 1 = third-order filter; 0 = second-order |
| ratio_i | input | RATIO_W | Decimation ratio R, in input samples |
| bit_clk_i | input | 1 | External bitstream clock (asynchronous) |
| bit_data_i | input | 1 | Bitstream data (asynchronous) |
| out_valid_o | output | 1 | One-cycle strobe marking a new output sample |
| out_data_o | output | ACC_W | Decimated two's-complement sample |

## Verification
In internal mode the output register is loaded on the same edge that takes the R-th sample of a period. A result is therefore due exactly R·(order+1) cycles after the first running edge, and every R cycles after that. The bench samples on the falling edge and compares arrival cycles exactly.

In external mode the two synchronizing flops and the edge detector add two to three system clocks of latency behind each bit-clock rise. The first result is checked inside a band of ±8 cycles around 6·R·(order+1), with a bit clock period of 6 cycles. The spacing between results is checked exactly at 6·R cycles.

Values are only compared for results that arrive after priming. The bench drives a pattern whose period divides R, so every steady result is k·R^(order−1) regardless of phase.

// File: rtl/sinc_pkg.sv
package sinc_pkg;
  localparam int unsigned MAX_ORDER = 3;
  localparam int unsigned HIST_LEN  = MAX_ORDER + 1;
  typedef enum logic { SRC_SYSCLK = 1'b0, SRC_BITCLK = 1'b1 } src_mode_e;
endpackage

// File: rtl/sinc_edge_sync.sv
module sinc_edge_sync
  import sinc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  src_mode_e mode,
  input  logic      bclk_raw,
  input  logic      bdat_raw,
  output logic      tick,
  output logic      sample
);
  logic clk_s1, clk_s2, clk_s3;
  logic dat_s1, dat_s2;
  logic rise_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_s1 <= 1'b0;
      clk_s2 <= 1'b0;
      clk_s3 <= 1'b0;
      dat_s1 <= 1'b0;
      dat_s2 <= 1'b0;
    end else begin
      clk_s1 <= bclk_raw;
      clk_s2 <= clk_s1;
      clk_s3 <= clk_s2;
      dat_s1 <= bdat_raw;
      dat_s2 <= dat_s1;
    end
  end

  assign rise_w = clk_s2 & ~clk_s3;
  assign tick   = (mode == SRC_BITCLK) ? rise_w : 1'b1;
  assign sample = dat_s2;

  // R4
  ext_tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SRC_BITCLK) && tick |=> !(tick && (mode == SRC_BITCLK)));
endmodule

// File: rtl/sinc_integ.sv
module sinc_integ
  import sinc_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic             sample,
  input  logic             ord3,
  output logic [ACC_W-1:0] last_o
);
  localparam logic [ACC_W-1:0] ONE = ACC_W'(1);

  logic [ACC_W-1:0] stage_w [MAX_ORDER];

  function automatic logic [ACC_W-1:0] bit_term(input logic b);
    logic signed [1:0] s;
    s = {1'b0, b};
    return ACC_W'(signed'(s));
  endfunction

  for (genvar g = 0; g < MAX_ORDER; g++) begin : gen_stage
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] feed_w;
    if (g == 0) begin : gen_first
      assign feed_w = bit_term(sample);
    end else begin : gen_next
      assign feed_w = stage_w[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc_q <= '0;
      else if (clr)    acc_q <= '0;
      else if (tick)   acc_q <= acc_q + feed_w;
    end
    assign stage_w[g] = acc_q;
  end

  assign last_o = ord3 ? stage_w[2] : stage_w[1];

  // R2
  ones_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick && !clr) |-> ((stage_w[0] - $past(stage_w[0])) <= ONE));
  // R10
  clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> (stage_w[0] == '0));
endmodule

// File: rtl/sinc_decim_cnt.sv
module sinc_decim_cnt #(
  parameter int RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               tick,
  input  logic [RATIO_W-1:0] ratio,
  output logic               boundary
);
  logic [RATIO_W-1:0] cnt_q;
  logic               at_end_w;

  assign at_end_w = (cnt_q == ratio - RATIO_W'(1));
  assign boundary = tick && at_end_w && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr)        cnt_q <= '0;
    else if (tick)       cnt_q <= at_end_w ? '0 : cnt_q + RATIO_W'(1);
  end

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio);
endmodule

// File: rtl/sinc_comb.sv
module sinc_comb
  import sinc_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             boundary,
  input  logic             ord3,
  input  logic [ACC_W-1:0] reading,
  output logic             valid_o,
  output logic [ACC_W-1:0] data_o
);
  localparam int CNT_W = $clog2(HIST_LEN + 1);

  logic [ACC_W-1:0] hist_q [HIST_LEN-1];
  logic [CNT_W-1:0] rd_cnt_q;
  logic [CNT_W-1:0] need_w;

  function automatic logic [ACC_W-1:0] diff_mix(
    input logic o3, input logic [ACC_W-1:0] a, input logic [ACC_W-1:0] b,
    input logic [ACC_W-1:0] c, input logic [ACC_W-1:0] d);
    if (o3) return a - (b + b + b) + (c + c + c) - d;
    return a - (b + b) + c;
  endfunction

  assign need_w = ord3 ? CNT_W'(4) : CNT_W'(3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < HIST_LEN - 1; i++) hist_q[i] <= '0;
      rd_cnt_q <= '0;
      valid_o  <= 1'b0;
      data_o   <= '0;
    end else if (clr) begin
      for (int i = 0; i < HIST_LEN - 1; i++) hist_q[i] <= '0;
      rd_cnt_q <= '0;
      valid_o  <= 1'b0;
    end else if (boundary) begin
      hist_q[0] <= reading;
      for (int i = 1; i < HIST_LEN - 1; i++) hist_q[i] <= hist_q[i-1];
      if (rd_cnt_q < CNT_W'(HIST_LEN)) rd_cnt_q <= rd_cnt_q + CNT_W'(1);
      if (rd_cnt_q >= need_w - CNT_W'(1)) begin
        valid_o <= 1'b1;
        data_o  <= diff_mix(ord3, reading, hist_q[0], hist_q[1], hist_q[2]);
      end else begin
        valid_o <= 1'b0;
      end
    end else begin
      valid_o <= 1'b0;
    end
  end

  // R6
  primed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (rd_cnt_q >= need_w));
endmodule

// File: rtl/sinc_decimator.sv
module sinc_decimator
  import sinc_pkg::*;
#(
  parameter int ACC_W   = 32,
  parameter int RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  logic               ext_mode_i,
  input  logic               order3_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               bit_clk_i,
  input  logic               bit_data_i,
  output logic               out_valid_o,
  output logic [ACC_W-1:0]   out_data_o
);
  localparam logic [RATIO_W-1:0] MIN_RATIO = RATIO_W'(2);

  src_mode_e          mode_q;
  logic               ord3_q;
  logic [RATIO_W-1:0] ratio_q;
  logic               clr_w;
  logic               tick_w;
  logic               sample_w;
  logic               boundary_w;
  logic [ACC_W-1:0]   last_w;

  assign clr_w = !run_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= SRC_SYSCLK;
      ord3_q  <= 1'b0;
      ratio_q <= MIN_RATIO;
    end else if (!run_i) begin
      mode_q  <= src_mode_e'(ext_mode_i);
      ord3_q  <= order3_i;
      ratio_q <= (ratio_i < MIN_RATIO) ? MIN_RATIO : ratio_i;
    end
  end

  sinc_edge_sync u_sync (
    .clk(clk), .rst_n(rst_n), .mode(mode_q),
    .bclk_raw(bit_clk_i), .bdat_raw(bit_data_i),
    .tick(tick_w), .sample(sample_w)
  );

  sinc_integ #(.ACC_W(ACC_W)) u_integ (
    .clk(clk), .rst_n(rst_n), .clr(clr_w), .tick(tick_w),
    .sample(sample_w), .ord3(ord3_q), .last_o(last_w)
  );

  sinc_decim_cnt #(.RATIO_W(RATIO_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr_w), .tick(tick_w),
    .ratio(ratio_q), .boundary(boundary_w)
  );

  sinc_comb #(.ACC_W(ACC_W)) u_comb (
    .clk(clk), .rst_n(rst_n), .clr(clr_w), .boundary(boundary_w),
    .ord3(ord3_q), .reading(last_w),
    .valid_o(out_valid_o), .data_o(out_data_o)
  );

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |=> !out_valid_o);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !out_valid_o);
  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i && $past(run_i) |-> ($stable(ratio_q) && $stable(ord3_q) && $stable(mode_q)));
endmodule

// File: tb/sinc_decimator_tb.sv
`timescale 1ns/1ps
module sinc_decimator_tb;
  localparam int ACC_W = 32;
  localparam int RATIO_W = 16;
  localparam int BPER = 6;

  typedef struct packed {
    logic        ext;
    logic        o3;
    logic [15:0] r;
    logic [7:0]  pat;
    logic [3:0]  plen;
    logic [1:0]  tag;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 16'd16,   8'h01, 4'd1, 2'd0, 32'd256},
    '{1'b0, 1'b1, 16'd16,   8'h01, 4'd1, 2'd1, 32'd4096},
    '{1'b0, 1'b0, 16'd16,   8'h00, 4'd1, 2'd0, 32'd0},
    '{1'b0, 1'b0, 16'd16,   8'h01, 4'd4, 2'd0, 32'd64},
    '{1'b0, 1'b1, 16'd8,    8'h01, 4'd2, 2'd1, 32'd256},
    '{1'b1, 1'b0, 16'd12,   8'h07, 4'd4, 2'd2, 32'd108},
    '{1'b1, 1'b1, 16'd8,    8'h01, 4'd1, 2'd2, 32'd512},
    '{1'b0, 1'b1, 16'd2000, 8'h01, 4'd1, 2'd3, 32'hDCD65000},
    '{1'b0, 1'b0, 16'd256,  8'h01, 4'd1, 2'd0, 32'd65536}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_i = 1'b0;
  logic ext_mode_i = 1'b0;
  logic order3_i = 1'b0;
  logic [RATIO_W-1:0] ratio_i = 16'd16;
  logic bit_clk_i = 1'b0;
  logic bit_data_i = 1'b0;
  logic out_valid_o;
  logic [ACC_W-1:0] out_data_o;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  int ng = 0;
  logic [31:0] gv [256];
  int gt [256];

  logic [7:0] pat = 8'h01;
  int plen = 1;
  logic drv_ext = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sinc_decimator #(.ACC_W(ACC_W), .RATIO_W(RATIO_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .ext_mode_i(ext_mode_i),
    .order3_i(order3_i), .ratio_i(ratio_i), .bit_clk_i(bit_clk_i),
    .bit_data_i(bit_data_i), .out_valid_o(out_valid_o), .out_data_o(out_data_o)
  );

  initial begin : drv
    int ph;
    int bidx;
    logic [15:0] lf;
    ph = 0; bidx = 0; lf = 16'hACE1;
    forever begin
      @(negedge clk);
      if (drv_ext) begin
        ph = (ph + 1) % BPER;
        bit_clk_i = (ph < BPER / 2);
        if (ph == BPER / 2) begin
          bit_data_i = pat[bidx % plen];
          bidx = (bidx + 1) % 840;
        end
      end else begin
        bit_data_i = pat[bidx % plen];
        bidx = (bidx + 1) % 840;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        bit_clk_i = lf[0];
      end
    end
  end

  initial begin : mon
    forever begin
      @(negedge clk);
      if (out_valid_o) begin
        gv[ng % 256] = out_data_o;
        gt[ng % 256] = cyc;
        ng = ng + 1;
      end
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string tag_name(input logic [1:0] t);
    case (t)
      2'd0: return "R2 R5";
      2'd1: return "R3 R5";
      2'd2: return "R4";
      default: return "R8";
    endcase
  endfunction

  task automatic run_vec(input vec_t v, input logic mess);
    int base, t0, per, d, want, tol;
    @(negedge clk);
    run_i = 1'b0;
    ext_mode_i = v.ext;
    order3_i = v.o3;
    ratio_i = v.r;
    drv_ext = v.ext;
    pat = v.pat;
    plen = int'(v.plen);
    repeat (30) @(negedge clk);
    base = ng;
    t0 = cyc;
    run_i = 1'b1;
    if (mess) begin
      repeat (5) @(negedge clk);
      ratio_i = 16'd5;
      order3_i = ~v.o3;
      ext_mode_i = ~v.ext;
    end
    while (ng < base + 3) @(negedge clk);
    per = v.ext ? BPER : 1;
    want = per * int'(v.r) * (v.o3 ? 4 : 3);
    tol = v.ext ? 8 : 0;
    d = gt[base % 256] - t0;
    nchk++;
    if (d < want - tol || d > want + tol) begin
      nfail++;
      $display("FAIL R6 first-valid actual=%0d expected=%0d", d, want);
    end
    for (int i = 1; i < 3; i++)
      chk(v.ext ? "R4 R7 spacing" : (mess ? "R9 spacing" : "R7 spacing"),
          gt[(base + i) % 256] - gt[(base + i - 1) % 256], per * int'(v.r));
    for (int i = 0; i < 3; i++)
      chk(mess ? "R9 value" : tag_name(v.tag), gv[(base + i) % 256], v.exp);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R7 actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin : main
    int held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", out_valid_o, 0);
    chk("R1 data", out_data_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 valid after release", out_valid_o, 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

    // R9: configuration changes while running are ignored
    run_vec(VECS[0], 1'b1);

    // R10: idle produces nothing even with a full-density stream
    @(negedge clk);
    run_i = 1'b0;
    drv_ext = 1'b0;
    pat = 8'h01;
    plen = 1;
    ratio_i = 16'd8;
    @(negedge clk);
    held = ng;
    repeat (200) @(negedge clk);
    chk("R10 idle outputs", ng - held, 0);

    // R9 ratio below 2 is used as 2: order 2, all ones -> 1*2*2 = 4? k=2, y=k*R=4
    run_vec('{1'b0, 1'b0, 16'd2, 8'h01, 4'd1, 2'd0, 32'd4}, 1'b0);
    begin
      vec_t v1;
      int base;
      @(negedge clk);
      run_i = 1'b0;
      ratio_i = 16'd1;
      order3_i = 1'b0;
      ext_mode_i = 1'b0;
      repeat (10) @(negedge clk);
      base = ng;
      run_i = 1'b1;
      while (ng < base + 4) @(negedge clk);
      chk("R9 ratio clamp spacing", gt[(base + 3) % 256] - gt[(base + 2) % 256], 2);
      chk("R9 ratio clamp value", gv[(base + 3) % 256], 4);
      v1 = VECS[0];
      run_i = 1'b0;
      run_vec(v1, 1'b0);
    end

    @(negedge clk);
    run_i = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule